// File: doc/BRIEF.md
# Multi-lane SPI slave shift engine

This block is the serial core of an SPI target device. While the chip-select input is held low, it moves bytes between the bus and two FIFO ports. Received groups of bits are gathered into bytes and written to a receive FIFO write port. Transmit bytes are taken from a transmit FIFO read port and shifted onto the output lanes. One data path handles one, two or four lanes, and the lane count is picked at run time. Clock polarity and phase select one of the four usual SPI modes. A separate control moves the transmit update onto the sampling edge, and this leaves reception unchanged.

All bus inputs are brought into the system clock through a synchroniser and then edge-detected. The system clock must therefore run at least four times faster than the serial clock. The block raises single-cycle strobes in four cases: chip select going active, chip select going inactive, a transmit fetch that finds the transmit FIFO empty, and a completed byte that finds the receive FIFO full. Register access, FIFO storage and interrupt merging are handled by neighbouring blocks.

Top module: `spis_engine`

## Requirements
- R1: `lane_mode` 0, 1 and 2 select 1, 2 and 4 lanes. A byte is received on `din[N-1:0]` and sent on `dout[N-1:0]` in groups of N bits, most significant group first. Within a group, the highest lane carries the highest bit. Code 3 is reserved and behaves as one lane.
- R2: Received groups are sampled on the rising serial-clock edge when `cpol` equals `cpha`, and on the falling edge otherwise. This gives correct reception in all four modes.
- R3: With `tx_inv` high, `dout` changes on the sampling edge instead of the opposite edge, and reception is unchanged.
- R4: With `enable` low, the block ignores the bus. It makes no FIFO pop or push, raises no strobe, and holds `dout_oe` low.
- R5: With `tx_en` low, the active lanes send all ones, and there is no pop and no underflow strobe.
- R6: With `rx_en` low, completed bytes cause neither a push nor an overflow strobe.
- R7: A transmit fetch made while `tx_en` is high and `tx_empty` is high raises `tx_underflow` for one cycle, and that byte goes out as all ones.
- R8: A completed byte while `rx_en` and `rx_full` are high raises `rx_overflow` for one cycle and is not pushed. Otherwise it is pushed with `rx_push` high for one cycle, with `rx_data` valid in the same cycle.
- R9: When enabled, a falling edge on `cs_n` raises `ss_assert` and a rising edge raises `ss_deassert`, each for exactly one cycle.
- R10: Deselecting in the middle of a byte discards the partial bits, and the next selection starts a fresh byte.
- R11: While the block is selected, `dout_oe` is high and the unused output lanes are 0. While it is not selected, `dout_oe` and `dout` are 0, and after reset all outputs are 0.
- R12: The first transmit byte is fetched at selection. Each following byte is fetched at the launch edge that ends the previous byte. When the first launch edge of a selection comes before any sampling edge (phase 1, not inverted), that edge is skipped. A transfer of K bytes therefore makes K fetches in that case and K+1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global on/off |
| tx_en | input | 1 | Transmit FIFO use enable |
| rx_en | input | 1 | Receive FIFO use enable |
| lane_mode | input | 2 | Lane count select (0: one, 1: two, 2: four) |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Serial clock phase |
| tx_inv | input | 1 | Move transmit update to the sampling edge |
| sclk | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Chip select, active low |
| din | input | 4 | Incoming data lanes |
| dout | output | 4 | Outgoing data lanes |
| dout_oe | output | 1 | Output lane drive enable |
| tx_data | input | DATA_W | Head of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Transmit FIFO read strobe, takes `tx_data` this cycle |
| rx_data | output | DATA_W | Byte to store |
| rx_push | output | 1 | Receive FIFO write strobe |
| rx_full | input | 1 | Receive FIFO full |
| tx_underflow | output | 1 | Fetch found no transmit byte |
| rx_overflow | output | 1 | Completed byte lost to a full receive FIFO |
| ss_assert | output | 1 | Chip select went active |
| ss_deassert | output | 1 | Chip select went inactive |

## Verification
The assertions rely on four properties of the inputs: `lane_mode` never holds the reserved code, serial-clock edges are several system clocks apart, `cs_n` and `sclk` never change in the same system clock, and the configuration changes only while chip select is inactive. Under these conditions fetch, push and chip-select strobes can never fall on consecutive cycles. The stimulus keeps to these limits. It uses half periods of eight system clocks and leaves idle gaps around each chip-select edge. It drives only codes 0 to 2 and sets up the mode, lane count and enables before each transfer. Unused input lanes are driven high so that any leak into the received data would show.

// File: rtl/spis_pkg.sv
`timescale 1ns/1ps
package spis_pkg;

   typedef enum logic [1:0] {
      LW_SINGLE = 2'd0,
      LW_DUAL   = 2'd1,
      LW_QUAD   = 2'd2,
      LW_RSVD   = 2'd3
   } lane_width_e;

   // number of active lanes for a lane_mode code; the reserved code acts as one lane
   function automatic int unsigned lanes_of(input logic [1:0] code);
      case (lane_width_e'(code))
         LW_DUAL: return 2;
         LW_QUAD: return 4;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/spis_sync.sv
`timescale 1ns/1ps
module spis_sync #(
   parameter int unsigned W      = 6,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spis_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= RST_VAL;
            else        stage_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spis_edge.sv
`timescale 1ns/1ps
module spis_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_s,
   input  logic cs_s,
   input  logic cpol,
   input  logic cpha,
   input  logic tx_inv,
   output logic sample_stb,
   output logic launch_stb,
   output logic cs_fall,
   output logic cs_rise
);

   logic prev_sclk_q, prev_cs_q;
   logic rise, fall, rise_samples;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sclk_q <= 1'b0;
         prev_cs_q   <= 1'b1;
      end else begin
         prev_sclk_q <= sclk_s;
         prev_cs_q   <= cs_s;
      end
   end

   always_comb begin
      rise         = sclk_s & ~prev_sclk_q;
      fall         = ~sclk_s & prev_sclk_q;
      rise_samples = ~(cpol ^ cpha);
      sample_stb   = rise_samples ? rise : fall;
      launch_stb   = tx_inv ? sample_stb : (rise_samples ? fall : rise);
      cs_fall      = prev_cs_q & ~cs_s;
      cs_rise      = ~prev_cs_q & cs_s;
   end

   AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb); // R2

endmodule

// File: rtl/spis_rx.sv
`timescale 1ns/1ps
module spis_rx
   import spis_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic              sel,
   input  logic [1:0]        lane_mode,
   input  logic [LANES-1:0]  din_s,
   input  logic              rx_en,
   input  logic              rx_full,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_push,
   output logic              rx_overflow
);

   localparam int unsigned CW = $clog2(DATA_W);

   logic [DATA_W-1:0] sr_q, sr_n, data_q;
   logic [CW-1:0]     cnt_q, last;
   logic [LANES-1:0]  lane_mask;
   logic              push_q, ovf_q;
   int unsigned       nl;

   always_comb begin
      nl        = lanes_of(lane_mode);
      last      = CW'(DATA_W / nl - 1);
      lane_mask = LANES'((1 << nl) - 1);
      sr_n      = (sr_q << nl) | DATA_W'(din_s & lane_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         cnt_q  <= '0;
         data_q <= '0;
         push_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         push_q <= 1'b0;
         ovf_q  <= 1'b0;
         if (!sel) begin
            sr_q  <= '0;
            cnt_q <= '0;
         end else if (sample) begin
            if (cnt_q == last) begin
               cnt_q <= '0;
               sr_q  <= '0;
               if (rx_en) begin
                  if (rx_full) begin
                     ovf_q <= 1'b1;
                  end else begin
                     push_q <= 1'b1;
                     data_q <= sr_n;
                  end
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
               sr_q  <= sr_n;
            end
         end
      end
   end

   assign rx_data     = data_q;
   assign rx_push     = push_q;
   assign rx_overflow = ovf_q;

   AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> $past(!rx_full)); // R8
   AST_PUSH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> !rx_push); // R1

endmodule

// File: rtl/spis_tx.sv
`timescale 1ns/1ps
module spis_tx
   import spis_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              launch,
   input  logic              sel,
   input  logic              skip_first,
   input  logic [1:0]        lane_mode,
   input  logic              tx_en,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_empty,
   output logic              tx_pop,
   output logic              tx_underflow,
   output logic [LANES-1:0]  dout,
   output logic              dout_oe
);

   localparam int unsigned CW = $clog2(DATA_W);

   logic [DATA_W-1:0] sr_q, fill;
   logic [CW-1:0]     cnt_q, last;
   logic [LANES-1:0]  lane_mask, top;
   logic              skip_q, need;
   int unsigned       nl;

   always_comb begin
      nl           = lanes_of(lane_mode);
      last         = CW'(DATA_W / nl - 1);
      lane_mask    = LANES'((1 << nl) - 1);
      need         = start | (launch & ~skip_q & (cnt_q == last));
      tx_pop       = need & tx_en & ~tx_empty;
      tx_underflow = need & tx_en & tx_empty;
      fill         = (tx_en & ~tx_empty) ? tx_data : '1;
      top          = sr_q[DATA_W-1 -: LANES] >> (LANES - nl);
      dout         = sel ? (top & lane_mask) : '0;
      dout_oe      = sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         cnt_q  <= '0;
         skip_q <= 1'b0;
      end else if (start) begin
         sr_q   <= fill;
         cnt_q  <= '0;
         skip_q <= skip_first;
      end else if (!sel) begin
         sr_q   <= '0;
         cnt_q  <= '0;
         skip_q <= 1'b0;
      end else if (launch) begin
         if (skip_q) begin
            skip_q <= 1'b0;
         end else if (cnt_q == last) begin
            sr_q  <= fill;
            cnt_q <= '0;
         end else begin
            sr_q  <= sr_q << nl;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_UNDER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underflow |=> (!dout_oe || dout == lane_mask)); // R7
   AST_POP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> !tx_pop); // R12

endmodule

// File: rtl/spis_engine.sv
`timescale 1ns/1ps
module spis_engine #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned LANES       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic [1:0]        lane_mode,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              tx_inv,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic [LANES-1:0]  din,
   output logic [LANES-1:0]  dout,
   output logic              dout_oe,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_empty,
   output logic              tx_pop,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_push,
   input  logic              rx_full,
   output logic              tx_underflow,
   output logic              rx_overflow,
   output logic              ss_assert,
   output logic              ss_deassert
);

   localparam int unsigned SW = LANES + 2;
   localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, {LANES{1'b0}}};

   if (LANES != 4) begin : g_bad_lanes
      $error("spis_engine: LANES must be 4");
   end
   if (DATA_W < LANES || DATA_W % LANES != 0) begin : g_bad_width
      $error("spis_engine: DATA_W must be a multiple of LANES");
   end

   logic [SW-1:0]    sync_q;
   logic [LANES-1:0] din_s;
   logic             sclk_s, cs_s;
   logic             sample_stb, launch_stb, cs_fall, cs_rise;
   logic             sel_q, ssa_q, ssd_q, start, samp, lnch;

   spis_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q(sync_q)
   );

   assign din_s  = sync_q[LANES-1:0];
   assign sclk_s = sync_q[LANES];
   assign cs_s   = sync_q[LANES+1];

   spis_edge u_edge (
      .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s(cs_s),
      .cpol(cpol), .cpha(cpha), .tx_inv(tx_inv),
      .sample_stb(sample_stb), .launch_stb(launch_stb),
      .cs_fall(cs_fall), .cs_rise(cs_rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         ssa_q <= 1'b0;
         ssd_q <= 1'b0;
      end else begin
         ssa_q <= enable & cs_fall;
         ssd_q <= enable & cs_rise;
         if (!enable || cs_rise) sel_q <= 1'b0;
         else if (cs_fall)       sel_q <= 1'b1;
      end
   end

   assign start = enable & cs_fall;
   assign samp  = enable & sel_q & sample_stb;
   assign lnch  = enable & sel_q & launch_stb;

   spis_rx #(.DATA_W(DATA_W), .LANES(LANES)) u_rx (
      .clk(clk), .rst_n(rst_n), .sample(samp), .sel(sel_q),
      .lane_mode(lane_mode), .din_s(din_s), .rx_en(rx_en), .rx_full(rx_full),
      .rx_data(rx_data), .rx_push(rx_push), .rx_overflow(rx_overflow)
   );

   spis_tx #(.DATA_W(DATA_W), .LANES(LANES)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .launch(lnch), .sel(sel_q),
      .skip_first(cpha & ~tx_inv), .lane_mode(lane_mode),
      .tx_en(tx_en), .tx_data(tx_data), .tx_empty(tx_empty),
      .tx_pop(tx_pop), .tx_underflow(tx_underflow),
      .dout(dout), .dout_oe(dout_oe)
   );

   assign ss_assert   = ssa_q;
   assign ss_deassert = ssd_q;

   AST_LANE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      lane_mode != 2'd3); // R1
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && $past(!enable)) |-> !(tx_pop || rx_push || ss_assert || ss_deassert || dout_oe)); // R4
   AST_SS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ss_assert |=> !ss_assert); // R9
   AST_SSD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ss_deassert |=> !ss_deassert); // R9

endmodule

// File: tb/spis_engine_test.sv
`timescale 1ns/1ps
module spis_engine_test;

   localparam int H = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enable = 0, tx_en = 0, rx_en = 0, cpol = 0, cpha = 0, tx_inv = 0;
   logic [1:0] lane_mode = 0;
   logic sclk = 0, cs_n = 1, rx_full = 0;
   logic [3:0] din = 4'hF;
   logic [3:0] dout;
   logic dout_oe, tx_pop, rx_push, tx_underflow, rx_overflow, ss_assert, ss_deassert;
   logic [7:0] rx_data, tx_data;
   logic tx_empty;

   logic [7:0] tq[$];
   logic [7:0] exp_rx[$];
   int total = 0, bad = 0;
   int n_push, n_pop, n_under, n_ovf, n_ssa, n_ssd;
   bit pop_pending = 0, prev_ssa = 0, prev_ssd = 0, done = 0;
   int seed = 0;

   always #4 clk = ~clk;

   assign tx_data  = (tq.size() != 0) ? tq[0] : 8'h00;
   assign tx_empty = (tq.size() == 0);

   spis_engine uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tx_en(tx_en), .rx_en(rx_en),
      .lane_mode(lane_mode), .cpol(cpol), .cpha(cpha), .tx_inv(tx_inv),
      .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout), .dout_oe(dout_oe),
      .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
      .rx_data(rx_data), .rx_push(rx_push), .rx_full(rx_full),
      .tx_underflow(tx_underflow), .rx_overflow(rx_overflow),
      .ss_assert(ss_assert), .ss_deassert(ss_deassert)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock reference: FIFO side effects and strobe widths
   always @(negedge clk) begin
      if (pop_pending && tq.size() != 0) void'(tq.pop_front());
      pop_pending = tx_pop;
      if (tx_pop)       n_pop++;
      if (tx_underflow) n_under++;
      if (rx_overflow)  n_ovf++;
      if (ss_assert)    n_ssa++;
      if (ss_deassert)  n_ssd++;
      if (rst_n) begin
         check(!(ss_assert && prev_ssa), "R9 ss_assert width", 2, 1);
         check(!(ss_deassert && prev_ssd), "R9 ss_deassert width", 2, 1);
      end
      prev_ssa = ss_assert;
      prev_ssd = ss_deassert;
      if (rx_push) begin
         n_push++;
         if (exp_rx.size() == 0) check(0, "R8 unexpected push", rx_data, 0);
         else begin
            check(rx_data == exp_rx[0], "R1 R2 received byte", rx_data, exp_rx[0]);
            void'(exp_rx.pop_front());
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic clear_counts();
      n_push = 0; n_pop = 0; n_under = 0; n_ovf = 0; n_ssa = 0; n_ssd = 0;
   endtask

   function automatic logic [3:0] drive(input logic [3:0] grp, input int nl);
      logic [3:0] m = 4'((1 << nl) - 1);
      return (grp & m) | ~m;
   endfunction

   task automatic xfer(input bit p_cpol, input bit p_cpha, input bit p_inv, input int lw,
                       input int nbytes, input int ntx, input bit f_en, input bit f_txen,
                       input bit f_rxen, input bit f_full, input string tag);
      int nl, groups, loads, e_pop, e_under, e_ovf, e_push;
      logic [3:0] mask;
      logic [7:0] m[$];
      logic [7:0] ex[$];
      nl = (lw == 1) ? 2 : (lw == 2) ? 4 : 1;
      groups = 8 / nl;
      mask = 4'((1 << nl) - 1);
      cpol = p_cpol; cpha = p_cpha; tx_inv = p_inv; lane_mode = 2'(lw);
      enable = f_en; tx_en = f_txen; rx_en = f_rxen; rx_full = f_full;
      sclk = p_cpol;
      tq.delete();
      for (int i = 0; i < ntx; i++) tq.push_back(8'(8'h71 + 29 * i + seed));
      for (int i = 0; i < nbytes; i++) m.push_back(8'(8'hA5 ^ (8'h3B * (i + 1)) ^ seed));
      for (int i = 0; i < nbytes; i++) ex.push_back((f_txen && i < ntx) ? tq[i] : 8'hFF);
      if (f_en && f_rxen && !f_full) foreach (m[i]) exp_rx.push_back(m[i]);
      loads   = f_en ? ((p_cpha && !p_inv) ? nbytes : nbytes + 1) : 0;
      e_pop   = (f_en && f_txen) ? ((loads < ntx) ? loads : ntx) : 0;
      e_under = (f_en && f_txen) ? loads - e_pop : 0;
      e_ovf   = (f_en && f_rxen && f_full) ? nbytes : 0;
      e_push  = (f_en && f_rxen && !f_full) ? nbytes : 0;
      seed = seed + 17;
      tick(6);
      clear_counts();
      cs_n = 0;
      tick(H);
      for (int b = 0; b < nbytes; b++) begin
         logic [7:0] got = 0;
         for (int g = 0; g < groups; g++) begin
            logic [3:0] grp = 4'((m[b] >> (8 - nl * (g + 1))) & 8'(mask));
            if (!p_cpha) begin
               din = drive(grp, nl);
               tick(H);
            end else begin
               sclk = ~p_cpol;
               din = drive(grp, nl);
               tick(H);
            end
            got = 8'((got << nl) | 8'(dout & mask));
            if (g == 0) begin
               if (f_en) begin
                  check(dout_oe == 1'b1, "R11 drive enable while selected", dout_oe, 1);
                  check((dout & ~mask) == 4'h0, "R11 unused lanes low", dout, dout & mask);
               end else begin
                  check(dout_oe == 1'b0, "R4 no drive when disabled", dout_oe, 0);
               end
            end
            if (!p_cpha) begin
               sclk = ~p_cpol;
               tick(H);
               sclk = p_cpol;
            end else begin
               sclk = p_cpol;
               tick(H);
            end
         end
         if (f_en) check(got == ex[b], {tag, " transmitted byte"}, got, ex[b]);
      end
      tick(H);
      cs_n = 1;
      tick(2 * H);
      check(n_pop == e_pop, {tag, " R12 fetch count"}, n_pop, e_pop);
      check(n_under == e_under, {tag, " R7 underflow count"}, n_under, e_under);
      check(n_ovf == e_ovf, {tag, " R8 overflow count"}, n_ovf, e_ovf);
      check(n_push == e_push, {tag, " push count"}, n_push, e_push);
      check(n_ssa == (f_en ? 1 : 0), {tag, " R9 select strobe"}, n_ssa, f_en);
      check(n_ssd == (f_en ? 1 : 0), {tag, " R9 deselect strobe"}, n_ssd, f_en);
      check(exp_rx.size() == 0, {tag, " pending bytes"}, exp_rx.size(), 0);
      check(dout_oe == 1'b0 && dout == 4'h0, "R11 idle after deselect", {dout_oe, dout}, 0);
      exp_rx.delete();
   endtask

   // R10: four bits then deselect
   task automatic partial();
      cpol = 0; cpha = 0; tx_inv = 0; lane_mode = 0;
      enable = 1; tx_en = 1; rx_en = 1; rx_full = 0; sclk = 0;
      tq.delete();
      tick(6);
      clear_counts();
      cs_n = 0;
      tick(H);
      for (int g = 0; g < 4; g++) begin
         din = {3'b111, g[0]};
         tick(H);
         sclk = 1; tick(H); sclk = 0;
      end
      tick(H);
      cs_n = 1;
      tick(2 * H);
      check(n_push == 0 && n_ovf == 0, "R10 partial byte dropped", n_push + n_ovf, 0);
      check(n_ssd == 1, "R10 R9 deselect seen", n_ssd, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(4);
      check({dout_oe, dout, tx_pop, rx_push, tx_underflow, rx_overflow, ss_assert, ss_deassert} == 0,
            "R11 outputs in reset", {dout_oe, dout}, 0);
      rst_n = 1;
      tick(4);
      check({dout_oe, dout, tx_pop, rx_push, ss_assert, ss_deassert} == 0,
            "R11 outputs after reset", {dout_oe, dout}, 0);
      xfer(0, 0, 0, 0, 2, 3, 1, 1, 1, 0, "R2 mode0 R1 single");
      xfer(0, 1, 0, 1, 2, 3, 1, 1, 1, 0, "R2 mode1 R1 dual");
      xfer(1, 0, 0, 2, 3, 4, 1, 1, 1, 0, "R2 mode2 R1 quad");
      xfer(1, 1, 0, 0, 1, 2, 1, 1, 1, 0, "R2 mode3 single");
      xfer(0, 0, 1, 0, 2, 3, 1, 1, 1, 0, "R3 mode0 inverted");
      xfer(0, 1, 1, 2, 2, 3, 1, 1, 1, 0, "R3 mode1 inverted quad");
      xfer(1, 1, 1, 1, 2, 3, 1, 1, 1, 0, "R3 mode3 inverted dual");
      xfer(0, 0, 0, 0, 3, 1, 1, 1, 1, 0, "R7 underflow");
      xfer(0, 1, 0, 1, 2, 0, 1, 1, 1, 0, "R7 underflow dual");
      xfer(0, 0, 0, 2, 2, 3, 1, 1, 1, 1, "R8 overflow");
      xfer(0, 0, 0, 0, 2, 3, 1, 0, 1, 0, "R5 tx disabled");
      xfer(0, 0, 0, 1, 2, 3, 1, 1, 0, 1, "R6 rx disabled");
      xfer(0, 0, 0, 0, 2, 3, 0, 1, 1, 0, "R4 disabled");
      partial();
      xfer(0, 0, 0, 0, 1, 2, 1, 1, 1, 0, "R10 fresh byte");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule